// File: doc/BRIEF.md
# Lookup-Table Logic Column with Carry and Cascade Links

This block is a vertical column of identical logic elements. Each element holds a 16-bit truth table that a 4-bit input selects from, so it can realize any function of four inputs with one output. The result can leave the element directly or through a D flip-flop. Two dedicated links join each element to the one above it. The carry link passes a carry bit so that elements can form ripple adders and counters. The cascade link combines an element's result with its lower neighbour's result by AND or OR, so that functions wider than four inputs need no general routing.

Each element has its own configuration word. The word sets the truth table and the mode bits, and it is written through a simple addressed configuration port. In arithmetic mode two inputs of an element act as operand bits, and the incoming carry takes the place of a third input. The truth table then supplies the sum bit, while fixed majority logic supplies the carry-out. The default column holds ten elements.

Top module: `lut_column`

## Requirements
- R1: When `cfg_we` is high at a rising clock edge, the element numbered `cfg_sel` stores `cfg_word`, and the new word takes effect after that edge. If `cfg_sel` is NUM_LE or above, no element changes. The word layout, from MSB to LSB, is truth table [20:5], arith [4], cascade enable [3], cascade OR select [2], bypass [1], first-element carry-in [0].
- R2: In normal mode an element's result is truth-table bit number {d3,d2,d1,d0}. For element i, d0 is `din[4i]` and d3 is `din[4i+3]`.
- R3: With bypass=1 an element's `dout` bit shows its result combinationally. With bypass=0 it shows the result captured at the most recent rising edge.
- R4: In arithmetic mode the table address is {d3, carry-in, d1, d0}, so d2 has no effect. The carry-out is the majority of d0, d1 and carry-in.
- R5: Element 0 takes its carry-in from bit [0] of its own configuration word. Every other element takes its carry-in from the carry-out of the element below it. An element that is not in arithmetic mode passes its carry-in through unchanged. `carry_out` is the carry-out of the last element.
- R6: With cascade enabled, an element's result is its table bit ANDed with the lower element's result (OR select=0), or ORed with it (OR select=1). Element 0 sees the identity value in its place: 1 for AND, 0 for OR, chosen by its own OR select bit.
- R7: When `sclr` is high at a rising edge, every element flip-flop is cleared. Configuration words are kept.
- R8: Asserting `rst_n` low clears all configuration words and flip-flops, so `dout` and `carry_out` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sclr | input | 1 | Synchronous clear of all element flip-flops |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | SEL_W | Index of the element to configure |
| cfg_word | input | 21 | Configuration word (layout in R1) |
| din | input | 4*NUM_LE | Four select inputs per element, element i at bits [4i+3:4i] |
| dout | output | NUM_LE | Result of each element |
| carry_out | output | 1 | Carry leaving the top of the column |

## Verification
Several behaviours are checked on every clock cycle by assertions:
- a configuration word loads and then holds,
- a flip-flop captures the combinational result or clears on `sclr`,
- in arithmetic mode, two set operand bits always generate a carry and two clear bits always kill it,
- a zero table bit forces an AND cascade low, and a one forces an OR cascade high.

Other behaviours only the bench scenarios can show. These are the exact ripple sum across four chained elements, the carry passing through non-arithmetic elements to the column output, the identity value at the foot of the cascade, the ignored third input in arithmetic mode, and the rejection of out-of-range configuration writes.

// File: rtl/lut_col_pkg.sv
package lut_col_pkg;
  localparam int LUT_K   = 4;
  localparam int TT_BITS = 1 << LUT_K;

  typedef struct packed {
    logic [TT_BITS-1:0] tt;
    logic               arith;
    logic               casc_en;
    logic               casc_or;
    logic               bypass;
    logic               cin;
  } le_cfg_t;

  localparam int CFG_W = $bits(le_cfg_t);
endpackage

// File: rtl/lut_cfg_reg.sv
module lut_cfg_reg
  import lut_col_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    we,
  input  le_cfg_t d,
  output le_cfg_t q
);
  le_cfg_t q_nx;

  always_comb begin
    q_nx = q;
    if (we) q_nx = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nx;
  end

  // R1: a written word is present after the edge
  p_cfg_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (q == $past(d)));
  // R1: without a write the word is unchanged
  p_cfg_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));
endmodule

// File: rtl/lut_cell.sv
module lut_cell
  import lut_col_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclr,
  input  le_cfg_t          cfg,
  input  logic [LUT_K-1:0] sel_in,
  input  logic             ci,
  input  logic             casc_in,
  output logic             co,
  output logic             casc_out,
  output logic             dout
);
  logic [LUT_K-1:0] addr;
  logic             lut_bit;
  logic             comb_val;
  logic             q, q_nx;

  always_comb begin
    addr = sel_in;
    if (cfg.arith) addr[2] = ci;
    lut_bit = cfg.tt[addr];
  end

  always_comb begin
    if (!cfg.casc_en)    comb_val = lut_bit;
    else if (cfg.casc_or) comb_val = lut_bit | casc_in;
    else                 comb_val = lut_bit & casc_in;
  end

  always_comb begin
    if (cfg.arith)
      co = (sel_in[0] & sel_in[1]) | (sel_in[0] & ci) | (sel_in[1] & ci);
    else
      co = ci;
  end

  always_comb begin
    q_nx = comb_val;
    if (sclr) q_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_nx;
  end

  assign casc_out = comb_val;
  assign dout     = cfg.bypass ? comb_val : q;

  p_sclr_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sclr |=> !q);
  p_reg_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sclr |=> (q == $past(comb_val)));
  p_and_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.casc_en && !cfg.casc_or && !lut_bit) |-> !casc_out);
  p_or_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.casc_en && cfg.casc_or && lut_bit) |-> casc_out);
  p_carry_gen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.arith && sel_in[0] && sel_in[1]) |-> co);
  p_carry_kill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.arith && !sel_in[0] && !sel_in[1]) |-> !co);
endmodule

// File: rtl/lut_column.sv
module lut_column
  import lut_col_pkg::*;
#(
  parameter  int NUM_LE = 10,
  localparam int SEL_W  = (NUM_LE > 1) ? $clog2(NUM_LE) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sclr,
  input  logic                    cfg_we,
  input  logic [SEL_W-1:0]        cfg_sel,
  input  logic [CFG_W-1:0]        cfg_word,
  input  logic [NUM_LE*LUT_K-1:0] din,
  output logic [NUM_LE-1:0]       dout,
  output logic                    carry_out
);
  logic    rst_meta, rst_sync;
  le_cfg_t cfg_q [NUM_LE];
  logic    carry [NUM_LE+1];
  logic    casc  [NUM_LE+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  assign carry[0]  = cfg_q[0].cin;
  assign casc[0]   = ~cfg_q[0].casc_or;
  assign carry_out = carry[NUM_LE];

  for (genvar i = 0; i < NUM_LE; i++) begin : g_le
    logic we_i;
    assign we_i = cfg_we && (cfg_sel == SEL_W'(i));

    lut_cfg_reg u_cfg (
      .clk   (clk),
      .rst_n (rst_sync),
      .we    (we_i),
      .d     (le_cfg_t'(cfg_word)),
      .q     (cfg_q[i])
    );

    lut_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_sync),
      .sclr     (sclr),
      .cfg      (cfg_q[i]),
      .sel_in   (din[i*LUT_K +: LUT_K]),
      .ci       (carry[i]),
      .casc_in  (casc[i]),
      .co       (carry[i+1]),
      .casc_out (casc[i+1]),
      .dout     (dout[i])
    );
  end
endmodule

// File: tb/lut_column_test.sv
module lut_column_test;
  localparam int NLE = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclr = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic [20:0] cfg_word = '0;
  logic [39:0] din = '0;
  logic [9:0]  dout;
  logic        carry_out;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  lut_column #(.NUM_LE(NLE)) uut (
    .clk(clk), .rst_n(rst_n), .sclr(sclr), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_word(cfg_word), .din(din),
    .dout(dout), .carry_out(carry_out)
  );

  // {cin, a[3:0], b[3:0]} for a four-element ripple adder
  localparam logic [8:0] ADD_VEC [8] = '{
    9'h000, 9'h035, 9'h178, 9'h0F1, 9'h1FF, 9'h0A5, 9'h10F, 9'h099
  };
  localparam logic [15:0] XOR3_TT = 16'h9696;
  localparam logic [15:0] PAT_TT  = 16'hA5C3;

  function automatic logic [20:0] mk(input logic [15:0] tt, input logic ar,
      input logic ce, input logic co, input logic by, input logic ci);
    return {tt, ar, ce, co, by, ci};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] sel, input logic [20:0] w);
    @(negedge clk);
    cfg_sel = sel; cfg_word = w; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(100000 * 8);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    logic [4:0] s;
    #18 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 dout after reset", 32'(dout), 32'h0);
    chk("R8 carry_out after reset", 32'(carry_out), 32'h0);

    // R2: normal mode table lookup, combinational
    wr(4'd2, mk(PAT_TT, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0));
    for (int idx = 0; idx < 16; idx++) begin
      @(negedge clk);
      din = 40'(idx) << 8;
      #1 chk("R2 table lookup", 32'(dout[2]), 32'(PAT_TT[idx]));
    end

    // R3: registered output
    wr(4'd2, mk(PAT_TT, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    @(negedge clk); din = 40'h0;
    @(posedge clk);
    @(negedge clk); din = 40'h2 << 8;
    #1 chk("R3 holds before edge", 32'(dout[2]), 32'h1);
    @(posedge clk); #1 chk("R3 updates after edge", 32'(dout[2]), 32'h0);

    // R7: synchronous clear
    @(negedge clk); din = 40'h0;
    @(posedge clk); #1 chk("R7 set before clear", 32'(dout[2]), 32'h1);
    @(negedge clk); sclr = 1'b1;
    #1 chk("R7 not yet cleared", 32'(dout[2]), 32'h1);
    @(posedge clk); #1 chk("R7 cleared", 32'(dout[2]), 32'h0);
    @(negedge clk); sclr = 1'b0;
    @(posedge clk); #1 chk("R7 config kept", 32'(dout[2]), 32'h1);

    // R1: out-of-range write ignored, in-range write isolated
    wr(4'd12, mk(16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0));
    #1 chk("R1 out of range ignored", 32'(dout), 32'h004);
    wr(4'd5, mk(16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0));
    #1 chk("R1 write to element 5 only", 32'(dout), 32'h024);

    // R4 / R5: ripple adder over elements 0..3, carry through 4..9
    for (int k = 1; k < 4; k++)
      wr(4'(k), mk(XOR3_TT, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0));
    for (int v = 0; v < 8; v++) begin
      wr(4'd0, mk(XOR3_TT, 1'b1, 1'b0, 1'b0, 1'b1, ADD_VEC[v][8]));
      @(negedge clk);
      din = '0;
      for (int k = 0; k < 4; k++) begin
        din[4*k]   = ADD_VEC[v][4+k];
        din[4*k+1] = ADD_VEC[v][k];
      end
      s = 5'(ADD_VEC[v][7:4]) + 5'(ADD_VEC[v][3:0]) + 5'(ADD_VEC[v][8]);
      #1 chk("R4 sum bits", 32'(dout[3:0]), 32'(s[3:0]));
      chk("R5 carry_out", 32'(carry_out), 32'(s[4]));
    end
    @(negedge clk);
    for (int k = 0; k < 4; k++) din[4*k+2] = 1'b1;
    #1 chk("R4 d2 ignored sum", 32'(dout[3:0]), 32'(s[3:0]));
    chk("R4 d2 ignored carry", 32'(carry_out), 32'(s[4]));

    // R6: AND cascade over elements 0..2
    for (int k = 0; k < 3; k++)
      wr(4'(k), mk(16'h8000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0));
    @(negedge clk); din = 40'hFFF;
    #1 chk("R6 AND all ones", 32'(dout[2]), 32'h1);
    chk("R6 AND identity at foot", 32'(dout[0]), 32'h1);
    @(negedge clk); din = 40'hFFD;
    #1 chk("R6 AND low input propagates", 32'(dout[2]), 32'h0);
    // R6: OR cascade
    for (int k = 0; k < 3; k++)
      wr(4'(k), mk(16'hFFFE, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0));
    @(negedge clk); din = 40'h0;
    #1 chk("R6 OR identity zero", 32'(dout[2]), 32'h0);
    @(negedge clk); din = 40'h200;
    #1 chk("R6 OR top input", 32'(dout[2]), 32'h1);
    @(negedge clk); din = 40'h001;
    #1 chk("R6 OR foot input propagates", 32'(dout[2]), 32'h1);

    summary();
    $finish;
  end
endmodule